// File: doc/BRIEF.md
# Pipelined Byte-Write SRAM Datapath

This block is the storage and data path of a synchronous pipelined static RAM. An address sequencer supplies a word address, a select flag and an access strobe each cycle, together with a note of whether the access was opened by the processor-side strobe. The block registers the request, works out which byte lanes to write from a global write override, a byte-write qualifier and one active-low enable per lane, and then either writes the chosen lanes into the array or reads the whole word into an output register.

Read data reaches `rdata_o` two rising edges after the request is sampled. A `drive_o` flag stands in for the bidirectional bus drivers. It is high only while output enable is low and the output register holds the result of a selected read. A sleep input stops all access while the array keeps its contents. Once sleep is released, the block ignores requests for a fixed number of wake-up edges.

The full-size part uses `ADDR_W = 15` (32768 words) with four byte lanes. The default build is smaller so the array stays small during elaboration.

Top module: `sram_pipe_dp`

## Requirements
- R1: The array holds 2^ADDR_W words of LANES*8 bits, and every address stores its word independently of every other address.
- R2: An accepted access with `gw_n_i` low writes all lanes with `wdata_i`, whatever `bwe_n_i` and `lane_n_i` are.
- R3: With `gw_n_i` high and `bwe_n_i` low, each lane i whose `lane_n_i[i]` is low writes bits 8i+7:8i. Lane 0 is bits 7:0 and lane 3 is bits 31:24. The other lanes keep their old bytes.
- R4: With `gw_n_i` high and either `bwe_n_i` high or all of `lane_n_i` high, the access is a read and the array is unchanged.
- R5: An access with `pstart_i` high is always a read, whatever the write enables are.
- R6: Data for a read request sampled at edge E appears on `rdata_o` after edge E+1 and not before.
- R7: A read of an address in the cycle right after a write to it returns the newly written bytes.
- R8: `drive_o` is high only when `oe_n_i` is low and the last completed output-stage operation was a selected read. A deselected access (`sel_i` low), a write or an idle cycle turns it off.
- R9: `rdata_o` keeps its value in every cycle in which no read completes.
- R10: While `sleep_i` is high, no access is accepted, `drive_o` is low from the next edge, and the stored contents are kept.
- R11: After `sleep_i` is seen low, requests at the next WAKE_CYC edges (3 by default) are ignored, and the following edge accepts them.
- R12: After reset, `drive_o` is low and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_i | input | 1 | Access strobe from the sequencer |
| sel_i | input | 1 | Device selected for this access |
| pstart_i | input | 1 | Access opened by the processor strobe (forced read) |
| addr_i | input | ADDR_W | Word address |
| gw_n_i | input | 1 | Global write override, active low |
| bwe_n_i | input | 1 | Byte-write qualifier, active low |
| lane_n_i | input | LANES | Per-lane write enables, active low |
| wdata_i | input | LANES*8 | Write data |
| oe_n_i | input | 1 | Output enable, active low |
| sleep_i | input | 1 | Power-down request, contents kept |
| rdata_o | output | LANES*8 | Registered read data |
| drive_o | output | 1 | Output drivers enabled |

## Verification
The bench builds the block with `ADDR_W = 6`, `LANES = 4` and `WAKE_CYC = 3`. With 64 words, a full sweep can write a distinct word to every address and read each one back, which covers the lowest and highest addresses and any aliasing between them. Four lanes give every single-lane write and a mixed pair. A three-edge wake window keeps the exact edge where requests are first accepted again short enough to probe one edge at a time.

// File: rtl/sram_dp_pkg.sv
// Shared definitions for the pipelined SRAM datapath.
// Assumes byte-wide lanes throughout.
package sram_dp_pkg;
    localparam int LANE_W = 8;

    // Kind of request held in the input stage.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/sram_wr_decode.sv
// Write-enable decoder: turns the global override, the byte qualifier and
// the per-lane enables into a lane write mask. A zero mask means read.
// Assumes all enables are active low; a processor-strobe access forces read.
module sram_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             pstart,
    output logic [LANES-1:0] wmask
);
    // Purpose: priority decode of the write controls into a lane mask.
    always_comb begin
        if (pstart) begin
            wmask = '0;
        end else if (!gw_n) begin
            wmask = '1;
        end else if (!bwe_n) begin
            wmask = ~lane_n;
        end else begin
            wmask = '0;
        end
    end
endmodule

// File: rtl/sram_wake_ctl.sv
// Sleep and wake-up control: reports when the array may be accessed.
// Assumes the sleep input is synchronous to clk; after it drops, WAKE_CYC
// edges pass before access is allowed again.
module sram_wake_ctl #(
    parameter int WAKE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    output logic awake_o
);
    localparam int CNT_W = $clog2(WAKE_CYC + 1);

    logic [CNT_W-1:0] wake_cnt;

    // Purpose: reload the wake counter while asleep, count it down after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_cnt <= '0;
        end else if (sleep_i) begin
            wake_cnt <= CNT_W'(WAKE_CYC);
        end else if (wake_cnt != '0) begin
            wake_cnt <= wake_cnt - 1'b1;
        end
    end

    // Purpose: access is allowed only when not asleep and the window is over.
    always_comb begin
        awake_o = !sleep_i && (wake_cnt == '0);
    end
endmodule

// File: rtl/sram_lane_array.sv
// Byte-lane storage array with a registered read port.
// One storage slice per lane, so each lane is written on its own.
// Assumes wr_en and rd_en are never high together.
module sram_lane_array #(
    parameter int ADDR_W = 9,
    parameter int LANES  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [LANES-1:0]    wmask,
    input  logic [LANES*8-1:0]  wdata,
    output logic [LANES*8-1:0]  rdata
);
    import sram_dp_pkg::*;
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q;

        // Purpose: write this lane's byte when the lane is enabled.
        always_ff @(posedge clk) begin
            if (wr_en && wmask[g]) begin
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // Purpose: output register for this lane, loaded only on a read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (rd_en) begin
                q <= mem[addr];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = q;
    end
endmodule

// File: rtl/sram_pipe_dp.sv
// Pipelined byte-write SRAM datapath (top).
// Stage 1 registers the accepted request and its lane mask. Stage 2 writes
// the array or loads the output register. Drive enable follows output enable
// and whether the output register holds a selected read.
// Assumes the sequencer keeps strobes quiet during the wake window.
module sram_pipe_dp #(
    parameter int ADDR_W   = 9,
    parameter int LANES    = 4,
    parameter int WAKE_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go_i,
    input  logic                sel_i,
    input  logic                pstart_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                gw_n_i,
    input  logic                bwe_n_i,
    input  logic [LANES-1:0]    lane_n_i,
    input  logic [LANES*8-1:0]  wdata_i,
    input  logic                oe_n_i,
    input  logic                sleep_i,
    output logic [LANES*8-1:0]  rdata_o,
    output logic                drive_o
);
    import sram_dp_pkg::*;
    localparam int DATA_W = LANES * LANE_W;

    logic               awake;
    logic [LANES-1:0]   wmask_d;
    logic               accept;
    op_e                op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [LANES-1:0]   wmask_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               wr_en;
    logic               rd_en;
    logic               out_valid_q;

    sram_wake_ctl #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep_i),
        .awake_o (awake)
    );

    sram_wr_decode #(.LANES(LANES)) u_dec (
        .gw_n   (gw_n_i),
        .bwe_n  (bwe_n_i),
        .lane_n (lane_n_i),
        .pstart (pstart_i),
        .wmask  (wmask_d)
    );

    // Purpose: a request is taken only when strobed, selected and awake.
    always_comb begin
        accept = go_i && sel_i && awake;
    end

    // Purpose: stage-1 request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_IDLE;
            addr_q  <= '0;
            wmask_q <= '0;
            wdata_q <= '0;
        end else begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            wmask_q <= accept ? wmask_d : '0;
            if (!accept) begin
                op_q <= OP_IDLE;
            end else if (wmask_d != '0) begin
                op_q <= OP_WRITE;
            end else begin
                op_q <= OP_READ;
            end
        end
    end

    // Purpose: stage-2 enables, blocked while sleep is requested.
    always_comb begin
        wr_en = (op_q == OP_WRITE) && !sleep_i;
        rd_en = (op_q == OP_READ)  && !sleep_i;
    end

    sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr_q),
        .wmask (wmask_q),
        .wdata (wdata_q),
        .rdata (rdata_o)
    );

    // Purpose: mark the output register as holding a selected read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
        end else begin
            out_valid_q <= rd_en;
        end
    end

    // Purpose: drivers on only for valid read data with output enable low.
    always_comb begin
        drive_o = out_valid_q && !oe_n_i;
    end
endmodule

// File: rtl/sram_pipe_dp_chk.sv
// Property checker for the pipelined SRAM datapath, bound into the top.
module sram_pipe_dp_chk #(
    parameter int LANES = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                go_i,
    input logic                sel_i,
    input logic                pstart_i,
    input logic                gw_n_i,
    input logic                oe_n_i,
    input logic                sleep_i,
    input logic                drive_o,
    input logic [LANES*8-1:0]  rdata_o,
    input logic                awake,
    input sram_dp_pkg::op_e    op_q,
    input logic [LANES-1:0]    wmask_q,
    input logic                rd_en
);
    import sram_dp_pkg::*;

    // R5: a processor-strobe access becomes a read.
    assert_pstart_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        go_i && sel_i && awake && pstart_i |=> op_q == OP_READ);

    // R2: the global write override enables every lane.
    assert_global_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go_i && sel_i && awake && !pstart_i && !gw_n_i
        |=> (op_q == OP_WRITE) && (&wmask_q));

    // R8: drivers never on while output enable is high.
    assert_drive_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |-> !oe_n_i);

    // R9: output register holds when no read completes.
    assert_hold_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata_o));

    // R10: sleep turns the drivers off from the next edge.
    assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> !drive_o);

    // R11: no request is taken within the wake window.
    assert_wake_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_q != OP_IDLE |-> !$past(sleep_i, 1) && !$past(sleep_i, 2)
                          && !$past(sleep_i, 3) && !$past(sleep_i, 4));
endmodule

bind sram_pipe_dp sram_pipe_dp_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (go_i),
    .sel_i    (sel_i),
    .pstart_i (pstart_i),
    .gw_n_i   (gw_n_i),
    .oe_n_i   (oe_n_i),
    .sleep_i  (sleep_i),
    .drive_o  (drive_o),
    .rdata_o  (rdata_o),
    .awake    (awake),
    .op_q     (op_q),
    .wmask_q  (wmask_q),
    .rd_en    (rd_en)
);

// File: tb/sram_pipe_dp_test.sv
`timescale 1ns/1ps
// Directed bench for the pipelined SRAM datapath.
module sram_pipe_dp_test;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int DW = NL * 8;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go_i = 1'b0;
    logic          sel_i = 1'b0;
    logic          pstart_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          gw_n_i = 1'b1;
    logic          bwe_n_i = 1'b1;
    logic [NL-1:0] lane_n_i = '1;
    logic [DW-1:0] wdata_i = '0;
    logic          oe_n_i = 1'b0;
    logic          sleep_i = 1'b0;
    logic [DW-1:0] rdata_o;
    logic          drive_o;

    int nchk = 0;
    int nfail = 0;
    logic [DW-1:0] model [NW];

    always #2 clk = ~clk;

    sram_pipe_dp #(.ADDR_W(AW), .LANES(NL), .WAKE_CYC(3)) uut (
        .clk(clk), .rst_n(rst_n), .go_i(go_i), .sel_i(sel_i),
        .pstart_i(pstart_i), .addr_i(addr_i), .gw_n_i(gw_n_i),
        .bwe_n_i(bwe_n_i), .lane_n_i(lane_n_i), .wdata_i(wdata_i),
        .oe_n_i(oe_n_i), .sleep_i(sleep_i), .rdata_o(rdata_o),
        .drive_o(drive_o)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one request for one edge, return at the following negedge.
    task automatic req(input logic g, input logic s, input logic p, input logic gw,
                       input logic bwe, input logic [NL-1:0] ln,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        go_i = g; sel_i = s; pstart_i = p; gw_n_i = gw; bwe_n_i = bwe;
        lane_n_i = ln; addr_i = a; wdata_i = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        req(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '1, '0, '0);
    endtask

    task automatic wr_all(input logic [AW-1:0] a, input logic [DW-1:0] d);
        req(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, a, d);
        model[a] = d;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input string tag);
        req(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '1, a, '0);
        idle();
        chk(tag, rdata_o, model[a]);
        chk({tag, " drive"}, {31'b0, drive_o}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R12 rdata", rdata_o, '0);
        chk("R12 drive", {31'b0, drive_o}, 32'd0);
    endtask

    task automatic t_sweep();
        for (int a = 0; a < NW; a++) wr_all(AW'(a), 32'h5A000000 ^ (a * 32'h01030507));
        for (int a = 0; a < NW; a++) rd_chk(AW'(a), "R1 sweep");
    endtask

    task automatic t_global();
        req(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 6'd20, 32'hDEADBEEF);
        model[20] = 32'hDEADBEEF;
        rd_chk(6'd20, "R2 override");
    endtask

    task automatic t_lanes();
        for (int i = 0; i < NL; i++) begin
            logic [DW-1:0] d;
            d = 32'hC3C3C3C3 ^ (32'h11111111 * (i + 1));
            req(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, ~(NL'(1) << i), 6'd5, d);
            model[5][i*8 +: 8] = d[i*8 +: 8];
            rd_chk(6'd5, "R3 lane");
        end
        req(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1010, 6'd6, 32'h12345678);
        model[6][7:0] = 8'h78;
        model[6][23:16] = 8'h34;
        rd_chk(6'd6, "R3 pair");
    endtask

    task automatic t_noread_write();
        req(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0000, 6'd8, 32'hFFFFFFFF);
        rd_chk(6'd8, "R4 qualifier high");
        req(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1111, 6'd8, 32'hFFFFFFFF);
        rd_chk(6'd8, "R4 lanes high");
    endtask

    task automatic t_pstart();
        req(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 6'd9, 32'h0BADF00D);
        idle();
        chk("R5 read data", rdata_o, model[9]);
        rd_chk(6'd9, "R5 unchanged");
    endtask

    task automatic t_latency();
        rd_chk(6'd1, "R6 setup");
        req(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '1, 6'd2, '0);
        chk("R6 early", rdata_o, model[1]);
        idle();
        chk("R6 on time", rdata_o, model[2]);
    endtask

    task automatic t_wr_rd();
        wr_all(6'd7, 32'hA1B2C3D4);
        rd_chk(6'd7, "R7 write then read");
    endtask

    task automatic t_drive();
        oe_n_i = 1'b1;
        req(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '1, 6'd3, '0);
        idle();
        chk("R8 oe high", {31'b0, drive_o}, 32'd0);
        oe_n_i = 1'b0;
        #0;
        chk("R8 oe low", {31'b0, drive_o}, 32'd1);
        req(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '1, 6'd4, '0);
        idle();
        chk("R8 deselect", {31'b0, drive_o}, 32'd0);
        chk("R9 hold", rdata_o, model[3]);
        req(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '1, 6'd3, '0);
        wr_all(6'd10, 32'h10101010);
        chk("R8 before write", {31'b0, drive_o}, 32'd1);
        idle();
        chk("R8 write", {31'b0, drive_o}, 32'd0);
        chk("R9 after write", rdata_o, model[3]);
    endtask

    task automatic t_sleep();
        logic [DW-1:0] old10;
        old10 = model[10];
        req(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '1, 6'd3, '0);
        sleep_i = 1'b1;
        idle();
        chk("R10 drive off", {31'b0, drive_o}, 32'd0);
        req(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 6'd10, 32'hEEEEEEEE);
        idle();
        sleep_i = 1'b0;
        req(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 6'd11, 32'h11111111);
        req(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 6'd12, 32'h22222222);
        req(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 6'd13, 32'h33333333);
        wr_all(6'd14, 32'h44444444);
        idle();
        chk("R10 retained", model[10], old10);
        rd_chk(6'd10, "R10 sleep write ignored");
        rd_chk(6'd11, "R11 wake edge 1");
        rd_chk(6'd12, "R11 wake edge 2");
        rd_chk(6'd13, "R11 wake edge 3");
        rd_chk(6'd14, "R11 first accepted");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sweep();
        t_global();
        t_lanes();
        t_noread_write();
        t_pstart();
        t_latency();
        t_wr_rd();
        t_drive();
        t_sleep();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule